// File: doc/BRIEF.md
# Paged Calibration Register Interface

This block is the host side of a calibration pulse controller. A host reaches every setting through a few offsets on a narrow synchronous bus. Offset 0 holds a page selector. The value last written there decides what the other offsets mean. Pages 0 to 3 open four independent pattern-memory fields. Page 8 opens the control/status byte, page 9 the bunch-crossing count, page A the fine delay, and page B the sequence restart pointer.

Page B also exposes the sequencer's live address at offset 4. The host can use it to watch the restart loop running.

Reads are strobed. The read data is chosen combinationally from the current page and offset, and it is captured in a register on the clock edge that samples the strobe. A separate port lets the downstream sequencer fetch pattern words without using the host bus. The stored control values are also presented continuously on outputs.

Top module: `paged_cal_regs`

## Requirements
- R1: After reset the page selector, every control register and every pattern word are zero, and `rdata` is zero.
- R2: A write at offset 0 stores `wdata[3:0]` as the page selector, which holds until the next write at offset 0. A read at offset 0 returns the selector zero-extended.
- R3: With page 0, 1, 2 or 3 selected, offset 2+2k (k below DEPTH) reaches 32-bit word k of that field. Word 0 sits at offset 2 and word 1 at offset 4. Each field keeps its own contents.
- R4: With page 8 selected, offset 2 writes `wdata[7:0]` into the control/status register, and a read returns it zero-extended.
- R5: With page 9 or page B selected, offset 2 writes `wdata[15:0]` into the bunch-crossing counter or the restart pointer respectively, and a read returns it zero-extended.
- R6: With page A selected, offset 2 writes `wdata[7:0]` into the fine-timing register. A read returns it with bits 31:8 all ones.
- R7: With page B selected, a read at offset 4 returns the `seq_addr` input (zero-extended) as it stood at the sampling edge. A write there changes nothing.
- R8: Page values 4–7 and C–F, odd offsets, pattern offsets beyond the field depth, and register-page offsets other than those above all read zero, and writes to them change no state.
- R9: `rdata` changes only on an edge where `rd_en` is high. In all other cycles it holds.
- R10: When a read and a write occur in the same cycle, the read returns the contents from before that write, including a page-selector write.
- R11: `seq_mem_data` shows word `seq_mem_idx` of field `seq_mem_field` combinationally. `csr_q`, `bxc_q`, `fine_q` and `restart_q` show the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (6) | Byte offset |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| seq_addr | input | RST_W (16) | Live sequence address from the sequencer |
| seq_mem_field | input | 2 | Sequencer field select |
| seq_mem_idx | input | log2(DEPTH) (4) | Sequencer word index |
| seq_mem_data | output | DATA_W (32) | Sequencer pattern word |
| csr_q | output | CSR_W (8) | Control/status value |
| bxc_q | output | BXC_W (16) | Bunch-crossing count |
| fine_q | output | FINE_W (8) | Fine delay |
| restart_q | output | RST_W (16) | Sequence restart pointer |

## Verification
A read and a write can land on the same edge. Both may target one pattern word. A read may also coincide with a write at offset 0 that changes the page under it. The bench issues these overlaps on purpose, both as a write and read of the same word in one cycle and as a selector write paired with a selector read. The behavioural model computes the read result from its state before it applies the write, so a design that forwards the new value, or that decodes with the new page, shows a mismatch at that cycle.

// File: rtl/cal_regs_pkg.sv
package cal_regs_pkg;

   localparam int PAGE_W = 4;

   localparam logic [PAGE_W-1:0] PG_CSR     = 4'h8;
   localparam logic [PAGE_W-1:0] PG_BXC     = 4'h9;
   localparam logic [PAGE_W-1:0] PG_FINE    = 4'hA;
   localparam logic [PAGE_W-1:0] PG_RESTART = 4'hB;

   typedef struct packed {
      logic       page_hit;
      logic       mem_hit;
      logic [1:0] mem_field;
      logic       csr_hit;
      logic       bxc_hit;
      logic       fine_hit;
      logic       rst_hit;
      logic       live_hit;
   } cal_sel_t;

endpackage

// File: rtl/cal_page_decode.sv
module cal_page_decode
   import cal_regs_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DEPTH  = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [PAGE_W-1:0] page,
   output cal_sel_t          sel,
   output logic [IDX_W-1:0]  idx
);

   logic              data_off;
   logic [ADDR_W-1:0] word;
   logic              word_ok;

   always_comb begin
      data_off = (addr != '0) && !addr[0];
      word     = (addr - ADDR_W'(2)) >> 1;
      word_ok  = data_off && (word < ADDR_W'(DEPTH));
      idx      = word[IDX_W-1:0];

      sel           = '0;
      sel.page_hit  = (addr == '0);
      sel.mem_hit   = word_ok && (page[3:2] == 2'b00);
      sel.mem_field = page[1:0];
      sel.csr_hit   = (addr == ADDR_W'(2)) && (page == PG_CSR);
      sel.bxc_hit   = (addr == ADDR_W'(2)) && (page == PG_BXC);
      sel.fine_hit  = (addr == ADDR_W'(2)) && (page == PG_FINE);
      sel.rst_hit   = (addr == ADDR_W'(2)) && (page == PG_RESTART);
      sel.live_hit  = (addr == ADDR_W'(4)) && (page == PG_RESTART);
   end

endmodule

// File: rtl/cal_pattern_mem.sv
module cal_pattern_mem #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int FIELDS = 4,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int FLD_W = $clog2(FIELDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [FLD_W-1:0]  wr_field,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [FLD_W-1:0]  rd_field,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic [FLD_W-1:0]  sq_field,
   input  logic [IDX_W-1:0]  sq_idx,
   output logic [DATA_W-1:0] sq_data
);

   logic [DATA_W-1:0] host_word [FIELDS];
   logic [DATA_W-1:0] seq_word  [FIELDS];

   for (genvar f = 0; f < FIELDS; f++) begin : g_field
      logic [DATA_W-1:0] cells [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
         end else if (we && (wr_field == FLD_W'(f))) begin
            cells[wr_idx] <= wdata;
         end
      end

      assign host_word[f] = cells[rd_idx];
      assign seq_word[f]  = cells[sq_idx];
   end

   assign rd_data = host_word[rd_field];
   assign sq_data = seq_word[sq_field];

endmodule

// File: rtl/cal_ctrl_regs.sv
module cal_ctrl_regs #(
   parameter int CSR_W  = 8,
   parameter int BXC_W  = 16,
   parameter int FINE_W = 8,
   parameter int RST_W  = 16,
   localparam int IN_W  = (BXC_W > RST_W) ? BXC_W : RST_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_csr,
   input  logic              we_bxc,
   input  logic              we_fine,
   input  logic              we_rst,
   input  logic [IN_W-1:0]   wdata,
   output logic [CSR_W-1:0]  csr_q,
   output logic [BXC_W-1:0]  bxc_q,
   output logic [FINE_W-1:0] fine_q,
   output logic [RST_W-1:0]  restart_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csr_q     <= '0;
         bxc_q     <= '0;
         fine_q    <= '0;
         restart_q <= '0;
      end else begin
         if (we_csr)  csr_q     <= wdata[CSR_W-1:0];
         if (we_bxc)  bxc_q     <= wdata[BXC_W-1:0];
         if (we_fine) fine_q    <= wdata[FINE_W-1:0];
         if (we_rst)  restart_q <= wdata[RST_W-1:0];
      end
   end

endmodule

// File: rtl/paged_cal_regs.sv
module paged_cal_regs
   import cal_regs_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int CSR_W  = 8,
   parameter int BXC_W  = 16,
   parameter int FINE_W = 8,
   parameter int RST_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   input  logic [RST_W-1:0]         seq_addr,
   input  logic [1:0]               seq_mem_field,
   input  logic [$clog2(DEPTH)-1:0] seq_mem_idx,
   output logic [DATA_W-1:0]        seq_mem_data,
   output logic [CSR_W-1:0]         csr_q,
   output logic [BXC_W-1:0]         bxc_q,
   output logic [FINE_W-1:0]        fine_q,
   output logic [RST_W-1:0]         restart_q
);

   localparam int IDX_W = $clog2(DEPTH);
   localparam int IN_W  = (BXC_W > RST_W) ? BXC_W : RST_W;

   if (DEPTH < 2) begin : g_chk_depth
      $error("DEPTH must be at least 2");
   end
   if ((2 * DEPTH + 2) > (1 << ADDR_W)) begin : g_chk_addr
      $error("ADDR_W too narrow for DEPTH words");
   end
   if ((DATA_W <= FINE_W) || (DATA_W < IN_W) || (DATA_W < CSR_W)) begin : g_chk_data
      $error("DATA_W narrower than a register");
   end

   logic [PAGE_W-1:0] page_q;
   cal_sel_t          sel;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] mem_rd;
   logic [DATA_W-1:0] rd_mux;

   cal_page_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dec (
      .addr (addr),
      .page (page_q),
      .sel  (sel),
      .idx  (idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     page_q <= '0;
      else if (wr_en && sel.page_hit) page_q <= wdata[PAGE_W-1:0];
   end

   cal_pattern_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FIELDS(4)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (wr_en && sel.mem_hit),
      .wr_field (sel.mem_field),
      .wr_idx   (idx),
      .wdata    (wdata),
      .rd_field (sel.mem_field),
      .rd_idx   (idx),
      .rd_data  (mem_rd),
      .sq_field (seq_mem_field),
      .sq_idx   (seq_mem_idx),
      .sq_data  (seq_mem_data)
   );

   cal_ctrl_regs #(.CSR_W(CSR_W), .BXC_W(BXC_W), .FINE_W(FINE_W), .RST_W(RST_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_csr    (wr_en && sel.csr_hit),
      .we_bxc    (wr_en && sel.bxc_hit),
      .we_fine   (wr_en && sel.fine_hit),
      .we_rst    (wr_en && sel.rst_hit),
      .wdata     (wdata[IN_W-1:0]),
      .csr_q     (csr_q),
      .bxc_q     (bxc_q),
      .fine_q    (fine_q),
      .restart_q (restart_q)
   );

   always_comb begin
      rd_mux = '0;
      if (sel.page_hit)      rd_mux = DATA_W'(page_q);
      else if (sel.mem_hit)  rd_mux = mem_rd;
      else if (sel.csr_hit)  rd_mux = DATA_W'(csr_q);
      else if (sel.bxc_hit)  rd_mux = DATA_W'(bxc_q);
      else if (sel.fine_hit) rd_mux = {{(DATA_W-FINE_W){1'b1}}, fine_q};
      else if (sel.rst_hit)  rd_mux = DATA_W'(restart_q);
      else if (sel.live_hit) rd_mux = DATA_W'(seq_addr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end

endmodule

// File: rtl/cal_regs_chk.sv
module cal_regs_chk
   import cal_regs_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int CSR_W  = 8,
   parameter int FINE_W = 8,
   parameter int RST_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [PAGE_W-1:0] wsel,
   input logic [DATA_W-1:0] rdata,
   input logic [RST_W-1:0]  seq_addr,
   input logic [PAGE_W-1:0] page_q,
   input logic [CSR_W-1:0]  csr_q
);

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R9

   AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == '0) |=> (page_q == $past(wsel))); // R2

   AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == '0) |=> $stable(page_q)); // R2

   AST_FINE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(2) && page_q == PG_FINE) |=> (&rdata[DATA_W-1:FINE_W])); // R6

   AST_LIVE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(4) && page_q == PG_RESTART) |=> (rdata == DATA_W'($past(seq_addr)))); // R7

   AST_UNUSED_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr != '0 && page_q[2] && !(page_q[3] && !page_q[2])) |=> (rdata == '0)); // R8

   AST_CSR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(2) && page_q == PG_CSR) |=> $stable(csr_q)); // R4

endmodule

bind paged_cal_regs cal_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CSR_W(CSR_W), .FINE_W(FINE_W), .RST_W(RST_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wsel     (wdata[3:0]),
   .rdata    (rdata),
   .seq_addr (seq_addr),
   .page_q   (page_q),
   .csr_q    (csr_q)
);

// File: tb/paged_cal_regs_tb_top.sv
module paged_cal_regs_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [15:0] seq_addr = 16'h0100;
   logic [1:0]  seq_mem_field = '0;
   logic [3:0]  seq_mem_idx = '0;
   logic [31:0] seq_mem_data;
   logic [7:0]  csr_q;
   logic [15:0] bxc_q;
   logic [7:0]  fine_q;
   logic [15:0] restart_q;

   always #2.5 clk = ~clk;

   paged_cal_regs dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .seq_addr(seq_addr),
      .seq_mem_field(seq_mem_field), .seq_mem_idx(seq_mem_idx),
      .seq_mem_data(seq_mem_data), .csr_q(csr_q), .bxc_q(bxc_q),
      .fine_q(fine_q), .restart_q(restart_q)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    started = 0;
   bit    done = 0;

   // behavioural reference state
   int unsigned m_page;
   logic [31:0] m_mem [4][16];
   logic [7:0]  m_csr;
   logic [15:0] m_bxc;
   logic [7:0]  m_fine;
   logic [15:0] m_rst;
   logic [31:0] m_rdata;

   function automatic logic [31:0] model_read(int a, logic [15:0] live);
      if (a == 0) return 32'(m_page);
      if (a % 2 == 1) return 0;
      if (m_page < 4) begin
         if ((a - 2) / 2 < 16) return m_mem[m_page][(a - 2) / 2];
         return 0;
      end
      if (a == 2) begin
         case (m_page)
            8:  return {24'h0, m_csr};
            9:  return {16'h0, m_bxc};
            10: return {24'hFFFFFF, m_fine};
            11: return {16'h0, m_rst};
            default: return 0;
         endcase
      end
      if (a == 4 && m_page == 11) return {16'h0, live};
      return 0;
   endfunction

   function automatic void model_write(int a, logic [31:0] d);
      if (a == 0) m_page = d % 16;
      else if (a % 2 == 0) begin
         if (m_page < 4) begin
            if ((a - 2) / 2 < 16) m_mem[m_page][(a - 2) / 2] = d;
         end else if (a == 2) begin
            case (m_page)
               8:  m_csr  = d[7:0];
               9:  m_bxc  = d[15:0];
               10: m_fine = d[7:0];
               11: m_rst  = d[15:0];
               default: ;
            endcase
         end
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_page = 0; m_csr = 0; m_bxc = 0; m_fine = 0; m_rst = 0; m_rdata = 0;
         for (int f = 0; f < 4; f++)
            for (int k = 0; k < 16; k++) m_mem[f][k] = 0;
      end else begin
         if (rd_en) m_rdata = model_read(int'(addr), seq_addr);   // R10: read before write
         if (wr_en) model_write(int'(addr), wdata);
      end
      started = 1;
   end

   task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %h expected %h", req, what, got, exp);
      end
   endtask

   // compare on every clock, away from the edge
   always @(negedge clk) begin
      if (started && !done) begin
         chk(cur_req, "rdata", rdata, m_rdata);
         chk("R11", "seq_mem_data", seq_mem_data, m_mem[seq_mem_field][seq_mem_idx]);
         chk("R11", "csr_q", {24'h0, csr_q}, {24'h0, m_csr});
         chk("R11", "bxc_q", {16'h0, bxc_q}, {16'h0, m_bxc});
         chk("R11", "fine_q", {24'h0, fine_q}, {24'h0, m_fine});
         chk("R11", "restart_q", {16'h0, restart_q}, {16'h0, m_rst});
      end
   end

   task automatic bus(input logic w, input logic r, input int a, input logic [31:0] d, input string req);
      @(posedge clk);
      #1;
      wr_en = w; rd_en = r; addr = 6'(a); wdata = d; cur_req = req;
      seq_addr = seq_addr + 16'd37;
      seq_mem_field = seq_mem_field + 2'd1;
      seq_mem_idx = seq_mem_idx + 4'd3;
   endtask

   task automatic finish_run();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 3; i++) bus(0, 0, 0, 0, "R1");
      @(posedge clk); #1 rst_n = 1'b1;
      bus(0, 1, 0, 0, "R1");
      bus(0, 1, 2, 0, "R1");

      // R2: selector latch and hold
      bus(1, 0, 0, 32'hFFFF_FFF2, "R2");
      bus(0, 1, 0, 0, "R2");
      bus(1, 0, 2, 32'h1111, "R2");
      bus(0, 1, 0, 0, "R2");

      // R3: fill and read back all four fields
      for (int f = 0; f < 4; f++) begin
         bus(1, 0, 0, f, "R3");
         for (int k = 0; k < 16; k++)
            bus(1, 0, 2 + 2 * k, 32'hA500_0000 ^ (f << 20) ^ (k * 32'h0001_0203), "R3");
      end
      for (int f = 3; f >= 0; f--) begin
         bus(1, 0, 0, f, "R3");
         for (int k = 0; k < 16; k++) bus(0, 1, 2 + 2 * k, 0, "R3");
      end

      // R8: unused offsets and pages
      bus(1, 0, 0, 0, "R8");
      bus(1, 0, 34, 32'hDEAD_BEEF, "R8");
      bus(1, 0, 3, 32'hDEAD_BEEF, "R8");
      bus(0, 1, 34, 0, "R8");
      bus(0, 1, 3, 0, "R8");
      bus(0, 1, 2, 0, "R8");
      for (int p = 4; p < 16; p++) begin
         if (p < 8 || p > 11) begin
            bus(1, 0, 0, p, "R8");
            bus(1, 0, 2, 32'hCAFE_F00D, "R8");
            bus(0, 1, 2, 0, "R8");
            bus(0, 1, 4, 0, "R8");
         end
      end
      bus(1, 0, 0, 0, "R8");
      bus(0, 1, 2, 0, "R8");

      // R4 control/status
      bus(1, 0, 0, 8, "R4");
      bus(1, 0, 2, 32'h0000_01FF, "R4");
      bus(0, 1, 2, 0, "R4");
      bus(1, 0, 4, 32'h55, "R8");
      bus(0, 1, 4, 0, "R8");
      bus(1, 0, 2, 32'h42, "R4");
      bus(0, 1, 2, 0, "R4");

      // R5 counter and restart pointer
      bus(1, 0, 0, 9, "R5");
      bus(1, 0, 2, 32'h1234_5678, "R5");
      bus(0, 1, 2, 0, "R5");
      bus(1, 0, 0, 11, "R5");
      bus(1, 0, 2, 32'hABCD_1234, "R5");
      bus(0, 1, 2, 0, "R5");

      // R6 fine delay with ones padding
      bus(1, 0, 0, 10, "R6");
      bus(1, 0, 2, 32'h0000_01C5, "R6");
      bus(0, 1, 2, 0, "R6");
      bus(1, 0, 2, 32'h0000_0000, "R6");
      bus(0, 1, 2, 0, "R6");

      // R7 live sequence address
      bus(1, 0, 0, 11, "R7");
      bus(1, 0, 4, 32'hFFFF, "R7");
      for (int i = 0; i < 4; i++) bus(0, 1, 4, 0, "R7");
      bus(0, 1, 2, 0, "R7");

      // R9 hold while no read strobe
      bus(0, 1, 0, 0, "R9");
      bus(0, 0, 2, 0, "R9");
      bus(1, 0, 0, 1, "R9");
      bus(0, 0, 4, 0, "R9");
      bus(0, 0, 6, 0, "R9");

      // R10 same-cycle read and write
      bus(1, 1, 6, 32'h7777_0001, "R10");
      bus(0, 1, 6, 0, "R10");
      bus(1, 1, 0, 3, "R10");
      bus(0, 1, 0, 0, "R10");
      bus(1, 1, 2, 32'h0BAD_0002, "R10");
      bus(0, 1, 2, 0, "R10");

      bus(0, 0, 0, 0, "R9");
      bus(0, 0, 0, 0, "R9");
      @(posedge clk); @(negedge clk); #1;
      finish_run();
   end

endmodule